// File: doc/BRIEF.md
# Memory Bus Direction Controller

This block produces the direction signal for the 16-bit data bus of an external memory port, together with the matching drive enable for the controller's own data pads. A memory-controller sequencer feeds it single-cycle event strobes: an access being launched, the output-enable edge of a read, the end of the access cycle, the read access time being reached and the read cycle time completing. It also gets the type of access (read or write), its timing style (synchronous or asynchronous), whether another access is queued and what type that access is.

The bus is driven outward by default. A read turns the bus inward when output-enable is asserted. The block then gives the bus back by one of two rules. With an explicit turnaround configured, it counts a programmable number of clocks after the end of the cycle. Without turnaround, it waits for the later of two points: a short delay after the access time, where the delay depends on the timing style, and the completion of the read cycle time. On a port with separate address and data lines, the bus stays inward between queued reads so that the direction line does not toggle. While a turnaround countdown is running, the block ignores new access launches, and it flags the countdown so that the sequencer holds off.

Top module: `membus_dir_ctrl`

## Requirements
- R1: `bus_dir` is 0 when the controller drives the data bus (out) and 1 when it receives (in). `dat_drive_en` is always the inverse of `bus_dir`.
- R2: During a write access, from the clock edge that samples `acc_start` up to and including the edge that samples `cyc_end`, `bus_dir` stays 0.
- R3: During a read access, `bus_dir` becomes 1 on the clock edge that samples `oe_assert`.
- R4: With `ta_enable`=1, a read sampled with `cyc_end` at edge k holds `bus_dir`=1 through edge k+N and releases it at edge k+N+1, where N is the 4-bit `ta_cycles` value (0..15). N=0 therefore releases on the first edge after the end of cycle.
- R5: With `ta_enable`=0 and `acc_sync`=0, a read whose `rd_acc_hit` is sampled at edge a and whose `rd_cyc_done` is sampled at edge c releases `bus_dir` to 0 at edge max(a+1, c).
- R6: With `ta_enable`=0 and `acc_sync`=1, the release edge is max(a+2, c).
- R7: At a release point with no queued read that can be held (or with nothing pending), `bus_dir` returns to 0 and stays there while idle.
- R8: At a release point with `addr_data_mux`=0, `acc_pending`=1 and `pend_is_read`=1, `bus_dir` stays 1 and remains 1 through the following read. With `addr_data_mux`=1 it returns to 0 instead.
- R9: Synchronous active-low reset: one edge with `rst_n`=0 leaves `bus_dir`=0 and `ta_busy`=0.
- R10: `ta_busy` is 1 from the edge that loads the countdown until the release edge. An `acc_start` sampled while the countdown is running is ignored, and `bus_dir` stays 1 until the countdown expires.
- R11: While the bus is held inward between reads, a write launch returns `bus_dir` to 0 on its `acc_start` edge, and a drop of `acc_pending` without a launch returns it to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | Strobe: an access is launched |
| acc_is_read | input | 1 | Type of the launched access: 1 read, 0 write |
| acc_sync | input | 1 | Timing style of the current read: 1 synchronous, 0 asynchronous |
| oe_assert | input | 1 | Strobe: read output-enable asserted |
| cyc_end | input | 1 | Strobe: end of the access cycle |
| rd_acc_hit | input | 1 | Strobe: read access time reached |
| rd_cyc_done | input | 1 | Strobe: read cycle time completed |
| acc_pending | input | 1 | Another access is queued |
| pend_is_read | input | 1 | Type of the queued access: 1 read |
| addr_data_mux | input | 1 | 1 when address and data share the bus |
| ta_enable | input | 1 | Use the explicit turnaround countdown |
| ta_cycles | input | 4 | Turnaround length in clocks |
| bus_dir | output | 1 | Data bus direction: 0 out, 1 in |
| dat_drive_en | output | 1 | Controller data pad drive enable |
| ta_busy | output | 1 | Turnaround countdown running; new launches are ignored |

## Verification
The embedded assertions check the per-cycle invariants on every cycle. These include an outward bus during writes and idle, an inward bus while held between reads or during a countdown, the switch on the output-enable edge, the countdown never stopping early, a running countdown that ignores launches, and the reset state. Only the bench scenarios can show the exact release edge. The bench sweeps every turnaround length and a grid of access-time and cycle-done offsets in both timing styles, and it compares the release edge against the later-of-two arithmetic. It also covers the multiplexed versus separate-bus difference in holding between reads.

// File: rtl/membus_dir_pkg.sv
// Package: shared types for the memory bus direction controller.
// Assumes: nothing beyond the standard language.
package membus_dir_pkg;

    // Sequencing states of the direction controller
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // no access, bus driven out
        ST_WR     = 3'd1,   // write in progress, bus out
        ST_RD_PRE = 3'd2,   // read launched, waiting for output enable
        ST_RD_IN  = 3'd3,   // read data phase, bus in
        ST_TURN   = 3'd4,   // turnaround countdown running, bus in
        ST_HOLD   = 3'd5    // bus kept in between two reads
    } bdir_state_t;

endpackage

// File: rtl/bdir_turn_counter.sv
// Module: turnaround countdown.
// Loads the programmed length at end of a read cycle and counts down to
// zero; expire is high in the cycle whose edge ends the countdown.
// Assumes: load is only raised while no countdown is running.
module bdir_turn_counter #(
    parameter int TA_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TA_W-1:0] length,
    output logic            busy,
    output logic            expire
);

    logic [TA_W-1:0] cnt_q;

    // Countdown register and running flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            cnt_q <= length;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Expiry flag for the sequencing FSM
    always_comb begin
        expire = busy && (cnt_q == '0);
    end

    AST_TA_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> busy);  // R4
    AST_TA_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && cnt_q == $past(length)));  // R4

endmodule

// File: rtl/bdir_read_window.sv
// Module: release window for reads without turnaround.
// Tracks the access-time point plus a style-dependent delay and the
// cycle-time completion; release is high in the cycle whose edge
// reaches the later of the two.
// Assumes: clr is pulsed when a read is accepted; strobes outside an
// active read are ignored.
module bdir_read_window #(
    parameter int ASYNC_DLY = 1,
    parameter int SYNC_DLY  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rd_active,
    input  logic sync_mode,
    input  logic acc_hit,
    input  logic cyc_done,
    output logic release_now
);

    localparam int MAX_DLY = (SYNC_DLY > ASYNC_DLY) ? SYNC_DLY : ASYNC_DLY;
    localparam int DLY_W   = $clog2(MAX_DLY + 1);
    localparam logic [DLY_W-1:0] LOAD_SYNC  = DLY_W'(SYNC_DLY - 1);
    localparam logic [DLY_W-1:0] LOAD_ASYNC = DLY_W'(ASYNC_DLY - 1);

    logic             armed_q;
    logic [DLY_W-1:0] dly_q;
    logic             acc_ok_q;
    logic             cyc_ok_q;
    logic             acc_ok_nxt;
    logic             cyc_ok_nxt;

    // Delay tracking after the access-time strobe and cycle-done flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed_q  <= 1'b0;
            dly_q    <= '0;
            acc_ok_q <= 1'b0;
            cyc_ok_q <= 1'b0;
        end else begin
            if (rd_active && acc_hit) begin
                armed_q <= 1'b1;
                dly_q   <= sync_mode ? LOAD_SYNC : LOAD_ASYNC;
            end else if (armed_q) begin
                if (dly_q == '0) begin
                    armed_q  <= 1'b0;
                    acc_ok_q <= 1'b1;
                end else begin
                    dly_q <= dly_q - 1'b1;
                end
            end
            if (rd_active && cyc_done) begin
                cyc_ok_q <= 1'b1;
            end
        end
    end

    // Release decision: both points reached at this edge
    always_comb begin
        acc_ok_nxt  = acc_ok_q || (armed_q && dly_q == '0);
        cyc_ok_nxt  = cyc_ok_q || (rd_active && cyc_done);
        release_now = acc_ok_nxt && cyc_ok_nxt;
    end

    AST_RW_DELAY_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && dly_q != '0 && !clr && !(rd_active && acc_hit))
        |=> (armed_q && !acc_ok_q));  // R6

endmodule

// File: rtl/bdir_seq_fsm.sv
// Module: direction sequencing FSM.
// Follows access events and drives the registered direction bit.
// Assumes: sequencer strobes are single-cycle and in access order.
module bdir_seq_fsm
    import membus_dir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_start,
    input  logic acc_is_read,
    input  logic oe_assert,
    input  logic cyc_end,
    input  logic acc_pending,
    input  logic pend_is_read,
    input  logic addr_data_mux,
    input  logic ta_enable,
    input  logic ta_expire,
    input  logic nt_release,
    output logic ta_load,
    output logic rd_clr,
    output logic rd_active,
    output logic dir_in
);

    bdir_state_t state_q, state_d;
    logic        dir_q, dir_d;
    logic        release_pt;
    logic        hold_ok;

    // Next state and next direction
    always_comb begin
        state_d    = state_q;
        dir_d      = dir_q;
        hold_ok    = !addr_data_mux && acc_pending && pend_is_read;
        release_pt = 1'b0;
        ta_load    = 1'b0;
        rd_clr     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                dir_d = 1'b0;
                if (acc_start) begin
                    state_d = acc_is_read ? ST_RD_PRE : ST_WR;
                    rd_clr  = acc_is_read;
                end
            end
            ST_WR: begin
                dir_d = 1'b0;
                if (cyc_end) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_PRE: begin
                if (oe_assert) begin
                    state_d = ST_RD_IN;
                    dir_d   = 1'b1;
                end
            end
            ST_RD_IN: begin
                if (ta_enable) begin
                    if (cyc_end) begin
                        state_d = ST_TURN;
                        ta_load = 1'b1;
                    end
                end else if (nt_release) begin
                    release_pt = 1'b1;
                end
            end
            ST_TURN: begin
                if (ta_expire) begin
                    release_pt = 1'b1;
                end
            end
            ST_HOLD: begin
                if (acc_start) begin
                    state_d = acc_is_read ? ST_RD_PRE : ST_WR;
                    dir_d   = acc_is_read;
                    rd_clr  = acc_is_read;
                end else if (!acc_pending) begin
                    state_d = ST_IDLE;
                    dir_d   = 1'b0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                dir_d   = 1'b0;
            end
        endcase
        if (release_pt) begin
            state_d = hold_ok ? ST_HOLD : ST_IDLE;
            dir_d   = hold_ok;
        end
    end

    // State and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    // Read window is active from launch to data phase
    always_comb begin
        rd_active = (state_q == ST_RD_PRE) || (state_q == ST_RD_IN);
        dir_in    = dir_q;
    end

    AST_WRITE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR) |-> !dir_q);  // R2
    AST_OE_TURNS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_PRE && oe_assert) |=> dir_q);  // R3
    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !dir_q);  // R7
    AST_HOLD_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> dir_q);  // R8
    AST_TURN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TURN && !ta_expire) |=> (state_q == ST_TURN && dir_q));  // R10
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE && !dir_q));  // R9

endmodule

// File: rtl/membus_dir_ctrl.sv
// Module: memory bus direction controller (top).
// Drives the data-bus direction and pad drive enable from sequencer
// strobes, with turnaround or later-of-two release after reads and
// inward hold between reads on a separate address/data port.
// Assumes: strobes are single-cycle; the sequencer holds a launch off
// while ta_busy is high.
module membus_dir_ctrl #(
    parameter int TA_W      = 4,
    parameter int ASYNC_DLY = 1,
    parameter int SYNC_DLY  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_start,
    input  logic            acc_is_read,
    input  logic            acc_sync,
    input  logic            oe_assert,
    input  logic            cyc_end,
    input  logic            rd_acc_hit,
    input  logic            rd_cyc_done,
    input  logic            acc_pending,
    input  logic            pend_is_read,
    input  logic            addr_data_mux,
    input  logic            ta_enable,
    input  logic [TA_W-1:0] ta_cycles,
    output logic            bus_dir,
    output logic            dat_drive_en,
    output logic            ta_busy
);

    logic ta_load;
    logic ta_expire;
    logic nt_release;
    logic rd_clr;
    logic rd_active;
    logic dir_in;

    bdir_seq_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_start    (acc_start),
        .acc_is_read  (acc_is_read),
        .oe_assert    (oe_assert),
        .cyc_end      (cyc_end),
        .acc_pending  (acc_pending),
        .pend_is_read (pend_is_read),
        .addr_data_mux(addr_data_mux),
        .ta_enable    (ta_enable),
        .ta_expire    (ta_expire),
        .nt_release   (nt_release),
        .ta_load      (ta_load),
        .rd_clr       (rd_clr),
        .rd_active    (rd_active),
        .dir_in       (dir_in)
    );

    bdir_turn_counter #(.TA_W(TA_W)) turn_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ta_load),
        .length(ta_cycles),
        .busy  (ta_busy),
        .expire(ta_expire)
    );

    bdir_read_window #(.ASYNC_DLY(ASYNC_DLY), .SYNC_DLY(SYNC_DLY)) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (rd_clr),
        .rd_active  (rd_active),
        .sync_mode  (acc_sync),
        .acc_hit    (rd_acc_hit),
        .cyc_done   (rd_cyc_done),
        .release_now(nt_release)
    );

    // Port outputs: direction and complementary pad drive enable
    always_comb begin
        bus_dir      = dir_in;
        dat_drive_en = !dir_in;
    end

    AST_COUNTDOWN_KEEPS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        ta_busy |-> bus_dir);  // R10
    AST_RESET_NO_COUNT: assert property (@(posedge clk)
        !rst_n |=> (!ta_busy && !bus_dir));  // R9

endmodule

// File: tb/membus_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module membus_dir_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_start = 0, acc_is_read = 0, acc_sync = 0, oe_assert = 0;
    logic       cyc_end = 0, rd_acc_hit = 0, rd_cyc_done = 0;
    logic       acc_pending = 0, pend_is_read = 0, addr_data_mux = 0, ta_enable = 0;
    logic [3:0] ta_cycles = 4'd0;
    logic       bus_dir, dat_drive_en, ta_busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    membus_dir_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_is_read(acc_is_read),
        .acc_sync(acc_sync), .oe_assert(oe_assert), .cyc_end(cyc_end),
        .rd_acc_hit(rd_acc_hit), .rd_cyc_done(rd_cyc_done), .acc_pending(acc_pending),
        .pend_is_read(pend_is_read), .addr_data_mux(addr_data_mux), .ta_enable(ta_enable),
        .ta_cycles(ta_cycles), .bus_dir(bus_dir), .dat_drive_en(dat_drive_en),
        .ta_busy(ta_busy)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Direction and its complement (R1) in one go
    task automatic chk_dir(input string req, input logic exp);
        chk(req, bus_dir, exp);
        chk("R1 drive enable", dat_drive_en, !exp);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        acc_start = 0; oe_assert = 0; cyc_end = 0; rd_acc_hit = 0; rd_cyc_done = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; pulse_clear(); step(); rst_n = 1;
    endtask

    // Launch a read and assert output enable; bus must be in afterwards
    task automatic start_read(input logic exp_after_start);
        acc_start = 1; acc_is_read = 1; step(); pulse_clear();
        chk_dir("R3 before OE", exp_after_start);
        oe_assert = 1; step(); pulse_clear();
        chk_dir("R3 after OE", 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step();
        rst_n = 1;
        step();
        // R9: reset state
        do_reset();
        chk_dir("R9 reset dir", 1'b0);
        chk("R9 reset ta_busy", ta_busy, 1'b0);

        // R2: write keeps bus out throughout
        acc_start = 1; acc_is_read = 0; step(); pulse_clear();
        for (int i = 0; i < 3; i++) begin
            chk_dir("R2 write", 1'b0); step();
        end
        cyc_end = 1; step(); pulse_clear();
        chk_dir("R2/R7 after write", 1'b0);

        // R4/R10: every turnaround length
        ta_enable = 1; addr_data_mux = 1;
        for (int n = 0; n < 16; n++) begin
            ta_cycles = 4'(n);
            start_read(1'b0);
            cyc_end = 1; step(); pulse_clear();
            chk("R10 busy after load", ta_busy, 1'b1);
            for (int j = 1; j <= n; j++) begin
                if (j == 1) begin acc_start = 1; acc_is_read = 0; end
                step(); pulse_clear();
                chk_dir("R4 countdown holds in", 1'b1);
                chk("R10 busy during countdown", ta_busy, 1'b1);
            end
            step();
            chk_dir("R4 release edge", 1'b0);
            chk("R10 busy cleared", ta_busy, 1'b0);
            step();
            chk_dir("R7/R10 idle after countdown", 1'b0);
        end

        // R5/R6: later-of-two release grid
        ta_enable = 0;
        for (int s = 0; s < 2; s++) begin
            for (int a = 1; a <= 4; a++) begin
                for (int c = 1; c <= 8; c++) begin
                    int rel;
                    rel = (a + 1 + s > c) ? (a + 1 + s) : c;
                    acc_sync = s[0];
                    start_read(1'b0);
                    for (int t = 1; t <= 10; t++) begin
                        if (t == a) rd_acc_hit = 1;
                        if (t == c) rd_cyc_done = 1;
                        step(); pulse_clear();
                        chk_dir(s ? "R6 sync release" : "R5 async release",
                                (t < rel) ? 1'b1 : 1'b0);
                    end
                end
            end
        end
        acc_sync = 0;

        // R8: separate bus holds in between reads
        addr_data_mux = 0; acc_pending = 1; pend_is_read = 1;
        start_read(1'b0);
        rd_acc_hit = 1; rd_cyc_done = 1; step(); pulse_clear();
        step();
        chk_dir("R8 hold after release", 1'b1);
        step();
        chk_dir("R8 hold stays", 1'b1);
        start_read(1'b1);
        // R11: pending drop from hold
        rd_acc_hit = 1; rd_cyc_done = 1; step(); pulse_clear();
        step();
        chk_dir("R8 hold again", 1'b1);
        acc_pending = 0; step();
        chk_dir("R11 pending drop", 1'b0);
        // R11: write launch from hold
        acc_pending = 1;
        start_read(1'b0);
        rd_acc_hit = 1; rd_cyc_done = 1; step(); pulse_clear();
        step();
        chk_dir("R8 hold third", 1'b1);
        acc_start = 1; acc_is_read = 0; step(); pulse_clear();
        chk_dir("R11 write from hold", 1'b0);
        cyc_end = 1; step(); pulse_clear();
        // R8: multiplexed bus does not hold
        addr_data_mux = 1;
        start_read(1'b0);
        rd_acc_hit = 1; rd_cyc_done = 1; step(); pulse_clear();
        step();
        chk_dir("R8 mux returns out", 1'b0);
        acc_pending = 0;

        // R9: reset in the middle of a read
        start_read(1'b0);
        do_reset();
        chk_dir("R9 mid-read reset", 1'b0);
        chk("R9 mid-read busy", ta_busy, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule